// File: doc/BRIEF.md
# Inverter gate protection sequencer

This block sits in front of the gate drivers of a three-phase bridge. It takes six active-high switching requests (one high-side and one low-side per phase) and forwards each one as a gate enable, but only while the protection state allows it. All analog conditions reach it as digital comparator flags. These are a short-circuit sense flag that has already been compared against the trip level, a trip/reset comparator pair for the low-side control supply, and one such pair for each high-side supply.

The protection is deliberately asymmetric. A qualified short circuit shuts off the three low-side gates together and drives the active-low fault line for a fixed number of cycles. A low-side supply dip also shuts off the low-side gates, and it holds the fault line for as long as the dip lasts, with a guaranteed minimum width. A dip on a high-side supply blanks only the gate of that phase and leaves the fault line released. After any blanking, a gate comes back only on a fresh rising edge of its request, so a request that is held high never switches a device on by accident.

Top module: `gate_guard`

## Requirements
- R1: After reset every gate output is 0 and fault_n is 1.
- R2: A short-circuit trip is accepted only after sc_sense has been 1 on SC_FILT_CYC consecutive clock edges. A shorter pulse changes no output.
- R3: In the cycle after the qualifying edge, all low-side gates are 0 and fault_n is 0. High-side gates are not affected by a short circuit.
- R4: A short-circuit fault holds fault_n at 0 for exactly FO_WIDTH_CYC cycles. A new qualified trip during that pulse reloads the full width.
- R5: After a short-circuit trip, the low-side gates stay 0 until one cycle after the fault pulse ends. They stay 0 even if their requests are held at 1.
- R6: The low-side under-voltage state is set on an edge where ls_uv_trip is 1 and cleared on an edge where only ls_uv_ok is 1. With neither flag it holds. When both flags are 1, trip wins.
- R7: While the low-side under-voltage state is set, all low-side gates are 0. fault_n is 0 for the whole condition and for at least FO_WIDTH_CYC cycles from its onset.
- R8: A gate turns on one cycle after its request is sampled rising, with no blanking active. It turns off in the same cycle its request goes to 0 or its blanking starts, and then needs a new rising edge.
- R9: Each high-side supply has its own trip/reset state with the same priority as R6. A set state forces only that phase's high-side gate to 0 and never drives fault_n.
- R10: A request that is already 1 when reset is released does not enable its gate until it has gone to 0 and back to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hs_req | input | PHASES | High-side switching requests, active high, bit i = phase i |
| ls_req | input | PHASES | Low-side switching requests, active high |
| sc_sense | input | 1 | Shunt current above trip level |
| ls_uv_trip | input | 1 | Low-side supply below trip threshold |
| ls_uv_ok | input | 1 | Low-side supply above reset threshold |
| hs_uv_trip | input | PHASES | Per-phase high-side supply below trip threshold |
| hs_uv_ok | input | PHASES | Per-phase high-side supply above reset threshold |
| hs_gate | output | PHASES | High-side gate enables |
| ls_gate | output | PHASES | Low-side gate enables |
| fault_n | output | 1 | Fault line, 0 = fault |

## Verification
The bench builds the block with SC_FILT_CYC = 4 and FO_WIDTH_CYC = 12, instead of the defaults (about 1.5 µs of filter and 2.4 ms of pulse at a fast clock). With these values, sense bursts shorter and longer than the filter fit into a few cycles. The full fault pulse, the overlapping retriggers, the release of the latched short-circuit state and the re-arm on the next edge all repeat many times within a short random run. Directed cases cover a request held high across reset and across a trip, a sense burst one cycle short of the filter, simultaneous trip and reset flags, and a one-cycle supply dip.

// File: rtl/gate_guard_pkg.sv
// Shared constants and helpers for the gate protection sequencer.
// Assumes all counters are sized from positive parameter values.
package gate_guard_pkg;

    // Number of bridge phases handled by one instance.
    localparam int unsigned NUM_PHASES = 3;

    // Bits needed to hold values 0..max_val.
    function automatic int unsigned cnt_bits(input int unsigned max_val);
        return (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction

endpackage

// File: rtl/gg_supply_mon.sv
// Hysteresis holder for one supply comparator pair.
// Assumes trip and ok are already synchronous to clk. Trip has priority.
module gg_supply_mon (
    input  logic clk,
    input  logic rst_n,
    input  logic trip,
    input  logic ok,
    output logic uv,
    output logic uv_enter
);

    logic uv_q;

    // Set on trip, clear on ok, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)    uv_q <= 1'b0;
        else if (trip) uv_q <= 1'b1;
        else if (ok)   uv_q <= 1'b0;
    end

    assign uv       = uv_q;
    assign uv_enter = trip && !uv_q;

    AST_UV_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (uv_q && !trip) |=> (uv_q == !$past(ok)));                        // R6

    AST_UV_TRIP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        trip |=> uv_q);                                                    // R6

endmodule

// File: rtl/gg_sc_filter.sv
// Qualifies the short-circuit sense flag over FILT consecutive edges.
// Emits a single-cycle fire pulse; sense must drop before it can fire again.
module gg_sc_filter #(
    parameter int unsigned FILT = 150
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sense,
    output logic fire
);
    import gate_guard_pkg::*;

    localparam int unsigned CW = cnt_bits(FILT);
    localparam logic [CW-1:0] LAST = CW'(FILT - 1);
    localparam logic [CW-1:0] DONE = CW'(FILT);

    logic [CW-1:0] run_q;

    // Count consecutive high samples, saturating past the firing point.
    always_ff @(posedge clk) begin
        if (!rst_n || !sense)  run_q <= '0;
        else if (run_q != DONE) run_q <= run_q + 1'b1;
    end

    assign fire = sense && (run_q == LAST);

    AST_FIRE_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> $past(sense));                                            // R2

endmodule

// File: rtl/gg_fault_timer.sv
// Fault pulse stretcher: a start loads WIDTH cycles. The fault line is low
// while the count runs or while hold is asserted.
module gg_fault_timer #(
    parameter int unsigned WIDTH = 240000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic hold,
    output logic busy,
    output logic fault_n
);
    import gate_guard_pkg::*;

    localparam int unsigned CW = cnt_bits(WIDTH);
    localparam logic [CW-1:0] FULL = CW'(WIDTH);

    logic [CW-1:0] left_q;

    // Reload on start, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)            left_q <= '0;
        else if (start)        left_q <= FULL;
        else if (left_q != '0) left_q <= left_q - 1'b1;
    end

    assign busy    = (left_q != '0);
    assign fault_n = !(busy || hold);

    AST_TIMER_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (left_q == FULL));                                       // R4

    AST_TIMER_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && busy) |=> (left_q == $past(left_q) - 1'b1));            // R4

endmodule

// File: rtl/gg_gate_arm.sv
// One gate re-arm cell. The gate follows the request only after a rising
// edge of the request has been seen with no blanking active. Blanking or a
// low request disarms the cell. The delayed request resets high, so a
// request held through reset does not count as an edge.
module gg_gate_arm (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic block,
    output logic gate
);

    logic req_d;
    logic armed_q;

    // Track the previous request level.
    always_ff @(posedge clk) begin
        if (!rst_n) req_d <= 1'b1;
        else        req_d <= req;
    end

    // Arm on a clean rising edge, disarm on blanking or release.
    always_ff @(posedge clk) begin
        if (!rst_n || block || !req) armed_q <= 1'b0;
        else if (!req_d)             armed_q <= 1'b1;
    end

    assign gate = req && armed_q && !block;

    AST_BLANK_FORCES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        block |-> !gate);                                                  // R9

    AST_ON_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate) |-> !$past(req, 2));                                   // R8

endmodule

// File: rtl/gate_guard.sv
// Inverter gate protection sequencer, top level.
// Gates six PWM requests with short-circuit and supply under-voltage
// protection. Assumes all flags are synchronous and SC_FILT_CYC >= 2.
module gate_guard #(
    parameter int unsigned PHASES       = gate_guard_pkg::NUM_PHASES,
    parameter int unsigned SC_FILT_CYC  = 150,
    parameter int unsigned FO_WIDTH_CYC = 240000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PHASES-1:0] hs_req,
    input  logic [PHASES-1:0] ls_req,
    input  logic              sc_sense,
    input  logic              ls_uv_trip,
    input  logic              ls_uv_ok,
    input  logic [PHASES-1:0] hs_uv_trip,
    input  logic [PHASES-1:0] hs_uv_ok,
    output logic [PHASES-1:0] hs_gate,
    output logic [PHASES-1:0] ls_gate,
    output logic              fault_n
);

    logic              sc_fire;
    logic              sc_lat_q;
    logic              ls_uv;
    logic              ls_uv_enter;
    logic              fo_busy;
    logic              ls_block;
    logic [PHASES-1:0] hs_uv;
    logic [PHASES-1:0] hs_uv_enter;

    gg_sc_filter #(.FILT(SC_FILT_CYC)) u_sc_filt (
        .clk(clk), .rst_n(rst_n), .sense(sc_sense), .fire(sc_fire)
    );

    gg_supply_mon u_ls_mon (
        .clk(clk), .rst_n(rst_n), .trip(ls_uv_trip), .ok(ls_uv_ok),
        .uv(ls_uv), .uv_enter(ls_uv_enter)
    );

    gg_fault_timer #(.WIDTH(FO_WIDTH_CYC)) u_fo (
        .clk(clk), .rst_n(rst_n), .start(sc_fire || ls_uv_enter),
        .hold(ls_uv), .busy(fo_busy), .fault_n(fault_n)
    );

    // Short-circuit latch: set by a trip, released once the pulse ends.
    always_ff @(posedge clk) begin
        if (!rst_n)        sc_lat_q <= 1'b0;
        else if (sc_fire)  sc_lat_q <= 1'b1;
        else if (!fo_busy) sc_lat_q <= 1'b0;
    end

    assign ls_block = sc_lat_q || ls_uv;

    generate
        for (genvar p = 0; p < PHASES; p++) begin : g_phase
            gg_supply_mon u_hs_mon (
                .clk(clk), .rst_n(rst_n), .trip(hs_uv_trip[p]), .ok(hs_uv_ok[p]),
                .uv(hs_uv[p]), .uv_enter(hs_uv_enter[p])
            );
            gg_gate_arm u_hs_arm (
                .clk(clk), .rst_n(rst_n), .req(hs_req[p]), .block(hs_uv[p]),
                .gate(hs_gate[p])
            );
            gg_gate_arm u_ls_arm (
                .clk(clk), .rst_n(rst_n), .req(ls_req[p]), .block(ls_block),
                .gate(ls_gate[p])
            );
        end
    endgenerate

    // Unused by design: high-side entry events raise no fault.
    logic unused_hs_enter;
    assign unused_hs_enter = ^hs_uv_enter;

    AST_SC_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        sc_fire |=> (!fault_n && ls_gate == '0));                          // R3

    AST_SC_LATCH_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        sc_lat_q |-> (ls_gate == '0));                                     // R5

    AST_UV_FAULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ls_uv |-> (!fault_n && ls_gate == '0));                            // R7

    AST_FAULT_ONLY_LOW_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ls_uv && !fo_busy) |-> fault_n);                                 // R9

endmodule

// File: tb/tb_gate_guard.sv
// Self-checking bench: cycle model built from the requirements, directed
// corner cases, then seeded random stimulus.
module tb_gate_guard;

    localparam int CLK_P = 10;
    localparam int NP    = 3;
    localparam int FILT  = 4;
    localparam int FOW   = 12;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [NP-1:0] hs_req, ls_req, hs_uv_trip, hs_uv_ok, hs_gate, ls_gate;
    logic          sc_sense, ls_uv_trip, ls_uv_ok, fault_n;

    int    n_chk = 0;
    int    n_bad = 0;
    string tag   = "R1";

    // Reference model state.
    logic [2*NP-1:0] m_reqd, m_arm;
    logic            m_lsuv, m_sclat;
    logic [NP-1:0]   m_hsuv;
    int              m_scc, m_fo;

    gate_guard #(.PHASES(NP), .SC_FILT_CYC(FILT), .FO_WIDTH_CYC(FOW)) dut (
        .clk(clk), .rst_n(rst_n), .hs_req(hs_req), .ls_req(ls_req),
        .sc_sense(sc_sense), .ls_uv_trip(ls_uv_trip), .ls_uv_ok(ls_uv_ok),
        .hs_uv_trip(hs_uv_trip), .hs_uv_ok(hs_uv_ok),
        .hs_gate(hs_gate), .ls_gate(ls_gate), .fault_n(fault_n)
    );

    always #(CLK_P/2) clk = ~clk;

    function automatic logic [2*NP-1:0] blocks();
        return {{NP{m_sclat | m_lsuv}}, m_hsuv};
    endfunction

    function automatic logic [2*NP-1:0] exp_gates();
        return {ls_req, hs_req} & m_arm & ~blocks();
    endfunction

    task automatic model_reset();
        m_reqd = '1; m_arm = '0; m_lsuv = 0; m_sclat = 0; m_hsuv = '0;
        m_scc = 0; m_fo = 0;
    endtask

    task automatic model_step();
        logic            fire, uv_in;
        logic [2*NP-1:0] req, blk;
        req   = {ls_req, hs_req};
        blk   = blocks();
        fire  = sc_sense && (m_scc == FILT - 1);
        uv_in = ls_uv_trip && !m_lsuv;
        m_sclat = fire ? 1'b1 : ((m_fo == 0) ? 1'b0 : m_sclat);
        m_fo    = (fire || uv_in) ? FOW : ((m_fo > 0) ? m_fo - 1 : 0);
        m_scc   = !sc_sense ? 0 : ((m_scc != FILT) ? m_scc + 1 : FILT);
        m_lsuv  = ls_uv_trip ? 1'b1 : (ls_uv_ok ? 1'b0 : m_lsuv);
        for (int i = 0; i < NP; i++)
            m_hsuv[i] = hs_uv_trip[i] ? 1'b1 : (hs_uv_ok[i] ? 1'b0 : m_hsuv[i]);
        for (int i = 0; i < 2*NP; i++)
            m_arm[i] = (blk[i] || !req[i]) ? 1'b0 : (!m_reqd[i] ? 1'b1 : m_arm[i]);
        m_reqd = req;
    endtask

    task automatic check_outputs();
        logic [2*NP-1:0] eg;
        logic            ef;
        eg = exp_gates();
        ef = !((m_fo != 0) || m_lsuv);
        n_chk++;
        if ({ls_gate, hs_gate} !== eg || fault_n !== ef) begin
            n_bad++;
            $display("FAIL %s t=%0t gates=%b fault_n=%b expected gates=%b fault_n=%b",
                     tag, $time, {ls_gate, hs_gate}, fault_n, eg, ef);
        end
    endtask

    // Called at a falling edge with inputs set: check, clock, advance model.
    task automatic tick();
        #1 check_outputs();
        @(posedge clk);
        model_step();
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        hs_req = '0; ls_req = '0; sc_sense = 0; ls_uv_trip = 0; ls_uv_ok = 0;
        hs_uv_trip = '0; hs_uv_ok = '0;
    endtask

    task automatic do_reset(input logic [NP-1:0] held);
        rst_n = 0; idle_inputs(); hs_req = held; ls_req = held;
        repeat (3) @(posedge clk);
        model_reset();
        @(negedge clk); rst_n = 1;
    endtask

    // Watchdog ends a hung run as a failure.
    initial begin
        #(CLK_P * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5a17));
        // R1 and R10: requests held high through reset stay off.
        do_reset('1);
        tag = "R1";
        tick();
        tag = "R10";
        repeat (4) tick();
        hs_req = '0; ls_req = '0; tick();
        hs_req = '1; ls_req = '1;
        tag = "R8"; repeat (3) tick();
        // R2: sense one cycle short of the filter.
        tag = "R2";
        sc_sense = 1; repeat (FILT - 1) tick();
        sc_sense = 0; repeat (3) tick();
        // R3 R5: qualified trip with requests held high.
        tag = "R3";
        sc_sense = 1; repeat (FILT) tick();
        sc_sense = 0; repeat (3) tick();
        tag = "R4";
        repeat (5) tick();
        sc_sense = 1; repeat (FILT) tick();          // retrigger mid-pulse
        sc_sense = 0; repeat (FOW + 2) tick();
        tag = "R5";
        repeat (3) tick();
        ls_req = '0; tick(); ls_req = '1; repeat (3) tick();
        // R6 R7: brief dip, then trip and ok together.
        tag = "R7";
        ls_uv_trip = 1; tick(); ls_uv_trip = 0; ls_uv_ok = 1; tick();
        ls_uv_ok = 0; repeat (FOW + 2) tick();
        tag = "R6";
        ls_uv_trip = 1; ls_uv_ok = 1; tick();
        ls_uv_trip = 0; ls_uv_ok = 0; repeat (FOW + 3) tick();
        ls_uv_ok = 1; tick(); ls_uv_ok = 0;
        ls_req = '0; tick(); ls_req = '1; repeat (2) tick();
        // R9: high-side dip on phase 1 only.
        tag = "R9";
        hs_uv_trip = 3'b010; tick(); hs_uv_trip = '0; repeat (3) tick();
        hs_uv_ok = 3'b010; tick(); hs_uv_ok = '0; repeat (2) tick();
        hs_req[1] = 0; tick(); hs_req[1] = 1; repeat (2) tick();
        // Random mix.
        tag = "R3 R4 R6 R8 R9 random";
        for (int c = 0; c < 4000; c++) begin
            for (int i = 0; i < NP; i++) begin
                if ($urandom_range(7) == 0) hs_req[i] = ~hs_req[i];
                if ($urandom_range(7) == 0) ls_req[i] = ~ls_req[i];
                hs_uv_trip[i] = ($urandom_range(199) == 0);
                hs_uv_ok[i]   = ($urandom_range(9) == 0);
            end
            if ($urandom_range(5) == 0) sc_sense = ~sc_sense;
            ls_uv_trip = ($urandom_range(149) == 0);
            ls_uv_ok   = ($urandom_range(9) == 0);
            tick();
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule